// File: doc/BRIEF.md
# Branch Trace Compressor

The block sits behind a program-trace capture point. Every clock it takes a 3-bit instruction status code, a 2-bit flush count and, for indirect branches, a 30-bit target address. Instruction reports are held in a short history, where a later flush can still retract them. Reports that leave the history unretracted are committed and turned into compact records. Runs of sequential instructions become a single count. Taken direct branches, not-taken branches and indirect flow changes each close the current run. An indirect record also carries its target address.

Records leave through a valid/ready stream. A small record FIFO absorbs back-pressure, and a sticky flag reports any record lost because that FIFO was full. The aim is to replace the raw per-clock trace with a stream that only shows how the instruction flow changed.

Top module: `bt_compress`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, rec_valid_o and ovf_o are 0.
- R2: Status codes are decoded as follows: 3'b001 is a sequential instruction, 3'b110 is a taken direct branch, 3'b101 is a taken indirect branch, and NT_CODE (default 3'b100) is a not-taken branch. Every other code (000, 010, 011, 111) is no report: it adds nothing to the history and emits no record.
- R3: A nonzero vfls_i = k retracts the k youngest uncommitted reports (all of them if fewer are held). The retraction is applied before the report in the same cycle is entered. A retracted report never affects any record or count.
- R4: A report is committed at the clock edge that samples the DEPTH-th later report (DEPTH = 4 by default). The record it produces is visible on rec_valid_o right after that edge. rec_valid_o can only rise after an edge that sampled a report with vfls_i = 0.
- R5: Each committed sequential report adds one to a pending count. Every emitted record restarts the pending count at 0.
- R6: A committed taken direct branch emits rec_type_o = 1, with rec_count_o equal to the pending count and rec_addr_o = 0.
- R7: A committed not-taken branch emits rec_type_o = 2, with the pending count and rec_addr_o = 0.
- R8: A committed taken indirect branch emits rec_type_o = 3, with the pending count and the addr_i value sampled in the cycle that reported it. All other record types carry address 0.
- R9: When a committed sequential report brings the pending count to 65535, a count-only record is emitted (rec_type_o = 0, rec_count_o = 65535) and the count restarts at 0.
- R10: Records leave in commit order. A record offered while rec_ready_i is low stays unchanged until it is accepted. Up to 4 records are buffered.
- R11: A record committed while the 4-entry FIFO is full is dropped, and ovf_o goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vf_i | input | 3 | Per-clock instruction status code |
| vfls_i | input | 2 | Number of youngest reports cancelled this cycle |
| addr_i | input | 30 | Indirect branch target, sampled with a 3'b101 report |
| rec_ready_i | input | 1 | Consumer accepts the offered record |
| rec_valid_o | output | 1 | A record is offered |
| rec_type_o | output | 2 | 0 count, 1 direct taken, 2 not taken, 3 indirect |
| rec_count_o | output | 16 | Sequential instructions before this record |
| rec_addr_o | output | 30 | Indirect target, 0 for other types |
| ovf_o | output | 1 | Sticky record-loss flag |

## Verification
A report becomes a record at the edge that samples the fourth later report, and the record is visible right after that edge. The flush count of that same edge decides whether anything commits at all. The bench drives every input at the falling edge and keeps its own model of the history, count and FIFO, advanced at the same point. It then compares rec_valid_o, the offered record and ovf_o at the next falling edge, which reflects exactly the rising edge between them. Because the number of buffered records is known in each cycle, a dropped record and the ovf_o change it causes are predicted for the right edge.

// File: rtl/bt_pkg.sv
package bt_pkg;
  parameter int unsigned VF_W   = 3;
  parameter int unsigned FLS_W  = 2;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned ADDR_W = 30;

  typedef enum logic [1:0] {K_SEQ = 2'd0, K_DIR = 2'd1, K_NT = 2'd2, K_IND = 2'd3} kind_e;
  typedef enum logic [1:0] {T_CNT = 2'd0, T_DIR = 2'd1, T_NT = 2'd2, T_IND = 2'd3} rtype_e;

  typedef struct packed {
    kind_e              kind;
    logic [ADDR_W-1:0]  addr;
  } ent_t;

  typedef struct packed {
    rtype_e             rtype;
    logic [CNT_W-1:0]   count;
    logic [ADDR_W-1:0]  addr;
  } rec_t;
endpackage

// File: rtl/bt_hist.sv
module bt_hist
  import bt_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  ent_t             ent_i,
  input  logic [FLS_W-1:0] flush_i,
  output logic             pop_o,
  output ent_t             pop_ent_o
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  ent_t             ent_q [DEPTH];
  logic [OCC_W-1:0] occ_q, occ_f;
  logic             full_f;

  // retraction precedes this cycle's entry
  always_comb begin
    if (OCC_W'(flush_i) >= occ_q) occ_f = '0;
    else                          occ_f = occ_q - OCC_W'(flush_i);
  end

  assign full_f    = (occ_f == OCC_W'(DEPTH));
  assign pop_o     = push_i && full_f;
  assign pop_ent_o = ent_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  occ_q <= '0;
    else if (push_i && !full_f)   occ_q <= occ_f + 1'b1;
    else                          occ_q <= occ_f;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g == DEPTH - 1) begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ent_q[g] <= '0;
        else if (push_i && (full_f || occ_f == OCC_W'(g))) ent_q[g] <= ent_i;
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ent_q[g] <= '0;
        else if (push_i && full_f) ent_q[g] <= ent_q[g+1];
        else if (push_i && occ_f == OCC_W'(g)) ent_q[g] <= ent_i;
      end
    end
  end
endmodule

// File: rtl/bt_commit.sv
module bt_commit
  import bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pop_i,
  input  ent_t ent_i,
  output logic push_o,
  output rec_t rec_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    push_o = 1'b0;
    rec_o  = '0;
    cnt_d  = cnt_q;
    if (pop_i) begin
      rec_o.count = cnt_q;
      unique case (ent_i.kind)
        K_SEQ: begin
          if (cnt_q == CNT_MAX - 1'b1) begin
            push_o      = 1'b1;
            rec_o.rtype = T_CNT;
            rec_o.count = CNT_MAX;
            cnt_d       = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        K_DIR: begin push_o = 1'b1; rec_o.rtype = T_DIR; cnt_d = '0; end
        K_NT:  begin push_o = 1'b1; rec_o.rtype = T_NT;  cnt_d = '0; end
        K_IND: begin
          push_o      = 1'b1;
          rec_o.rtype = T_IND;
          rec_o.addr  = ent_i.addr;
          cnt_d       = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bt_fifo.sv
module bt_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en, rd_en;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign wr_en   = push_i && !full_o;
  assign rd_en   = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= wr_q + 1'b1;
      if (rd_en) rd_q <= rd_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[g] <= '0;
      else if (wr_en && wr_q == PTR_W'(g)) mem_q[g] <= data_i;
    end
  end
endmodule

// File: rtl/bt_compress.sv
module bt_compress
  import bt_pkg::*;
#(
  parameter int unsigned      HIST_DEPTH = 4,
  parameter int unsigned      FIFO_DEPTH = 4,
  parameter logic [VF_W-1:0]  NT_CODE    = 3'b100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VF_W-1:0]   vf_i,
  input  logic [FLS_W-1:0]  vfls_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rec_ready_i,
  output logic              rec_valid_o,
  output logic [1:0]        rec_type_o,
  output logic [CNT_W-1:0]  rec_count_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic              ovf_o
);
  localparam int unsigned REC_W = $bits(rec_t);

  logic rpt_vld, pop, rec_push, fifo_full, ovf_q;
  ent_t rpt_ent, pop_ent;
  rec_t rec_new, rec_head;

  always_comb begin
    rpt_vld      = 1'b1;
    rpt_ent.addr = addr_i;
    rpt_ent.kind = K_SEQ;
    if (vf_i == NT_CODE) rpt_ent.kind = K_NT;
    else begin
      case (vf_i)
        3'b001:  rpt_ent.kind = K_SEQ;
        3'b110:  rpt_ent.kind = K_DIR;
        3'b101:  rpt_ent.kind = K_IND;
        default: rpt_vld = 1'b0;
      endcase
    end
  end

  bt_hist #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (rpt_vld),
    .ent_i     (rpt_ent),
    .flush_i   (vfls_i),
    .pop_o     (pop),
    .pop_ent_o (pop_ent)
  );

  bt_commit u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pop_i  (pop),
    .ent_i  (pop_ent),
    .push_o (rec_push),
    .rec_o  (rec_new)
  );

  bt_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rec_push),
    .data_i  (rec_new),
    .full_o  (fifo_full),
    .valid_o (rec_valid_o),
    .ready_i (rec_ready_i),
    .data_o  (rec_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ovf_q <= 1'b0;
    else if (rec_push && fifo_full) ovf_q <= 1'b1;
  end

  assign ovf_o       = ovf_q;
  assign rec_type_o  = rec_head.rtype;
  assign rec_count_o = rec_head.count;
  assign rec_addr_o  = rec_head.addr;
endmodule

// File: rtl/bt_compress_chk.sv
module bt_compress_chk
  import bt_pkg::*;
#(
  parameter logic [VF_W-1:0] NT_CODE = 3'b100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VF_W-1:0]   vf_i,
  input logic [FLS_W-1:0]  vfls_i,
  input logic              rec_ready_i,
  input logic              rec_valid_o,
  input logic [1:0]        rec_type_o,
  input logic [CNT_W-1:0]  rec_count_o,
  input logic [ADDR_W-1:0] rec_addr_o,
  input logic              ovf_o
);
  logic is_rpt;
  assign is_rpt = (vf_i == 3'b001) || (vf_i == 3'b110) || (vf_i == 3'b101) || (vf_i == NT_CODE);

  always @(posedge clk_i)
    if (!rst_ni) p_reset_idle_r1: assert (!rec_valid_o && !ovf_o);

  p_rise_after_report_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_valid_o) |-> ($past(is_rpt) && $past(vfls_i) == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_type_o)
                                   && $stable(rec_count_o) && $stable(rec_addr_o));

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_count_max_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_type_o == 2'd0 |-> &rec_count_o);

  p_addr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_type_o != 2'd3 |-> rec_addr_o == '0);
endmodule

bind bt_compress bt_compress_chk #(.NT_CODE(NT_CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vf_i        (vf_i),
  .vfls_i      (vfls_i),
  .rec_ready_i (rec_ready_i),
  .rec_valid_o (rec_valid_o),
  .rec_type_o  (rec_type_o),
  .rec_count_o (rec_count_o),
  .rec_addr_o  (rec_addr_o),
  .ovf_o       (ovf_o)
);

// File: tb/sim_bt_compress.sv
module sim_bt_compress;
  localparam int CLK_PERIOD = 10;
  localparam int HDEPTH     = 4;
  localparam int FDEPTH     = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  vf_i = '0;
  logic [1:0]  vfls_i = '0;
  logic [29:0] addr_i = '0;
  logic        rec_ready_i = 1'b0;
  logic        rec_valid_o, ovf_o;
  logic [1:0]  rec_type_o;
  logic [15:0] rec_count_o;
  logic [29:0] rec_addr_o;

  int checks = 0;
  int fails  = 0;
  int cnt_recs = 0;
  logic [47:0] exp_q[$];
  logic [31:0] hq[$];
  int  m_cnt = 0;
  bit  m_ovf = 1'b0;
  string ctx = "";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bt_compress u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vf_i(vf_i), .vfls_i(vfls_i), .addr_i(addr_i),
    .rec_ready_i(rec_ready_i), .rec_valid_o(rec_valid_o), .rec_type_o(rec_type_o),
    .rec_count_o(rec_count_o), .rec_addr_o(rec_addr_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  // R2 decode: -1 means no report
  function automatic int kind_of(input logic [2:0] vf);
    case (vf)
      3'b001: return 0;
      3'b110: return 1;
      3'b100: return 2;
      3'b101: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic emit(input logic [1:0] t, input int c, input logic [29:0] a, input int pre);
    if (pre >= FDEPTH) m_ovf = 1'b1;   // R11 drop
    else exp_q.push_back({t, c[15:0], a});
  endtask

  task automatic commit(input logic [31:0] e, input int pre);
    case (e[31:30])
      2'd0: if (m_cnt == 65534) begin emit(2'd0, 65535, '0, pre); m_cnt = 0; end
            else m_cnt++;
      2'd1: begin emit(2'd1, m_cnt, '0, pre); m_cnt = 0; end
      2'd2: begin emit(2'd2, m_cnt, '0, pre); m_cnt = 0; end
      default: begin emit(2'd3, m_cnt, e[29:0], pre); m_cnt = 0; end
    endcase
  endtask

  task automatic step(input logic [2:0] vf, input logic [1:0] fl, input logic [29:0] ad, input logic rdy);
    int pre;
    int k;
    bit popd;
    logic [47:0] act;
    logic [31:0] e;
    @(negedge clk_i);
    pre = exp_q.size();
    vf_i = vf; vfls_i = fl; addr_i = ad; rec_ready_i = rdy;
    chk(ovf_o == m_ovf, "R11", {47'd0, ovf_o}, {47'd0, m_ovf});
    chk(rec_valid_o == (pre > 0), "R4", {47'd0, rec_valid_o}, {47'd0, pre > 0});
    popd = 1'b0;
    if (rec_valid_o && rdy && pre > 0) begin
      act = {rec_type_o, rec_count_o, rec_addr_o};
      case (exp_q[0][47:46])
        2'd0: begin chk(act == exp_q[0], "R9", act, exp_q[0]); cnt_recs++; end
        2'd1: chk(act == exp_q[0], "R6", act, exp_q[0]);
        2'd2: chk(act == exp_q[0], "R7", act, exp_q[0]);
        default: chk(act == exp_q[0], "R8", act, exp_q[0]);
      endcase
      popd = 1'b1;
    end
    // R3 retraction before entry
    for (int i = 0; i < fl; i++) if (hq.size() > 0) void'(hq.pop_back());
    k = kind_of(vf);
    if (k >= 0) begin
      hq.push_back({k[1:0], ad});
      if (hq.size() > HDEPTH) begin
        e = hq.pop_front();
        commit(e, pre);
      end
    end
    if (popd) void'(exp_q.pop_front());
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; vf_i = '0; vfls_i = '0; addr_i = '0; rec_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!rec_valid_o && !ovf_o, "R1", {46'd0, rec_valid_o, ovf_o}, 48'd0);
    exp_q.delete(); hq.delete(); m_cnt = 0; m_ovf = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rec_valid_o && !ovf_o, "R1", {46'd0, rec_valid_o, ovf_o}, 48'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] ign [4];
    ign[0] = 3'b000; ign[1] = 3'b010; ign[2] = 3'b011; ign[3] = 3'b111;
    void'($urandom(32'd5821));

    ctx = "reset";
    do_reset();

    // R4: four reports stay buffered, the fifth commits the first
    ctx = "latency R4";
    for (int i = 0; i < 4; i++) step(3'b110, 2'd0, '0, 1'b0);
    step(3'b000, 2'd0, '0, 1'b0);
    chk(!rec_valid_o, "R4", {47'd0, rec_valid_o}, 48'd0);
    step(3'b110, 2'd0, '0, 1'b0);
    step(3'b000, 2'd0, '0, 1'b0);
    chk(rec_valid_o && rec_type_o == 2'd1 && rec_count_o == 16'd0, "R4",
        {rec_type_o, rec_count_o, 29'd0, rec_valid_o}, {2'd1, 16'd0, 29'd0, 1'b1});
    for (int i = 0; i < 3; i++) step(3'b000, 2'd0, '0, 1'b1);

    // R3/R5: flush retracts youngest, including over-large flush
    do_reset();
    ctx = "flush R3";
    step(3'b001, 2'd0, '0, 1'b1);
    step(3'b001, 2'd0, '0, 1'b1);
    step(3'b110, 2'd0, '0, 1'b1);
    step(3'b001, 2'd1, '0, 1'b1);
    step(3'b101, 2'd3, 30'h1abc, 1'b1);
    step(3'b101, 2'd3, 30'h2def, 1'b1);
    step(3'b001, 2'd0, '0, 1'b1);
    step(3'b001, 2'd0, '0, 1'b1);
    step(3'b100, 2'd0, '0, 1'b1);
    for (int i = 0; i < 5; i++) step(3'b110, 2'd0, '0, 1'b1);
    for (int i = 0; i < 3; i++) step(3'b000, 2'd0, '0, 1'b1);

    // R2: ignored codes interleaved with reports
    ctx = "ignored R2";
    for (int i = 0; i < 40; i++) step((i % 2) ? ign[i % 4] : 3'b001, 2'd0, 30'h3fff_ffff, 1'b1);
    for (int i = 0; i < 5; i++) step(3'b101, 2'd0, 30'(i * 7 + 1), 1'b1);
    for (int i = 0; i < 3; i++) step(3'b000, 2'd0, '0, 1'b1);

    // R10/R11: back-pressure, fill, drop
    do_reset();
    ctx = "stall R10 R11";
    for (int i = 0; i < 9; i++) step(i[0] ? 3'b110 : 3'b100, 2'd0, '0, 1'b0);
    for (int i = 0; i < 4; i++) step(3'b000, 2'd0, '0, 1'b0);
    chk(ovf_o, "R11", {47'd0, ovf_o}, 48'd1);
    for (int i = 0; i < 7; i++) step(3'b000, 2'd0, '0, 1'b1);
    chk(exp_q.size() == 0 && !rec_valid_o, "R10", {47'd0, rec_valid_o}, 48'd0);

    // R9: count saturation
    do_reset();
    ctx = "saturate R9";
    cnt_recs = 0;
    for (int i = 0; i < 65540; i++) step(3'b001, 2'd0, '0, 1'b1);
    for (int i = 0; i < 5; i++) step(3'b110, 2'd0, '0, 1'b1);
    for (int i = 0; i < 3; i++) step(3'b000, 2'd0, '0, 1'b1);
    chk(cnt_recs == 1, "R9", 48'(cnt_recs), 48'd1);

    // random mix
    do_reset();
    ctx = "random";
    for (int i = 0; i < 30000; i++) begin
      int r;
      logic [2:0] vf;
      logic [1:0] fl;
      r = $urandom % 16;
      if (r < 5) vf = 3'b001;
      else if (r < 7) vf = 3'b110;
      else if (r < 8) vf = 3'b101;
      else if (r < 10) vf = 3'b100;
      else vf = ign[$urandom % 4];
      fl = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      step(vf, fl, 30'($urandom), ($urandom % 8) != 0);
    end
    for (int i = 0; i < 5; i++) step(3'b110, 2'd0, '0, 1'b1);
    for (int i = 0; i < 8; i++) step(3'b000, 2'd0, '0, 1'b1);
    chk(exp_q.size() == 0, "R10", 48'(exp_q.size()), 48'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule